// File: doc/BRIEF.md
# Second-Operand Shift and Rotate Unit

This combinational unit forms the second ALU operand of a 32-bit datapath. The first operand never passes through it. In immediate mode it expands a 12-bit field into a 32-bit constant. The low eight bits of the field are a value. The top four bits are a rotate count. The value is rotated right by twice that count, so the rotation is any even number from 0 to 30.

In register mode it shifts or rotates a 32-bit register value. A 2-bit code picks the operation: logical left, logical right, arithmetic right or rotate right. There is no rotate-left operation. A left rotate by n is done as a right rotate by 32 minus n. The shift amount comes from a 5-bit field in the instruction or from the bottom byte of a second register. Alongside the operand, the unit produces the shifter carry-out: the last bit shifted out, or the incoming carry when nothing moves.

Top module: `op2_shifter`

## Requirements
- R1: In immediate mode with a rotate count of 0 (imm12_i[11:8] = 0), operand_o equals imm12_i[7:0] zero-extended and carry_o equals carry_i.
- R2: In immediate mode with a nonzero rotate count r, operand_o is imm12_i[7:0] rotated right by 2*r and carry_o equals operand_o[31]; for example r = 4 places the byte in bits 31:24.
- R3: When amt_sel_reg_i = 1, the shift amount is rs_val_i[7:0] and rs_val_i[31:8] has no effect; when amt_sel_reg_i = 0, the amount is amt_imm_i.
- R4: In register mode with a shift amount of 0, operand_o equals rm_val_i and carry_o equals carry_i, whatever the shift code.
- R5: Code 2'b00 (logical left) by n in 1..31 gives rm_val_i << n with carry rm_val_i[32-n]. An amount of 32 gives 0 with carry rm_val_i[0]. Amounts above 32 give 0 with carry 0.
- R6: Code 2'b01 (logical right, zero fill) by n in 1..31 gives rm_val_i >> n with carry rm_val_i[n-1]. An amount of 32 gives 0 with carry rm_val_i[31]. Amounts above 32 give 0 with carry 0.
- R7: Code 2'b10 (arithmetic right) by n in 1..31 fills the top bits with copies of rm_val_i[31] and gives carry rm_val_i[n-1]. Amounts of 32 or more give 32 copies of the sign bit with carry rm_val_i[31].
- R8: Code 2'b11 (rotate right) uses the amount modulo 32. A nonzero remainder rotates the value and sets carry to operand_o[31]. A nonzero amount that is a multiple of 32 leaves the value unchanged with carry rm_val_i[31].
- R9: A rotate right by 32-n equals a rotate left by n, i.e. (x << n) | (x >> (32-n)).
- R10: In immediate mode, rm_val_i, rs_val_i, shift_code_i, amt_sel_reg_i and amt_imm_i have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_mode_i | input | 1 | 1: expand the 12-bit immediate; 0: shift the register value |
| imm12_i | input | 12 | Immediate field: [11:8] rotate count, [7:0] value |
| rm_val_i | input | 32 | Register value to shift |
| shift_code_i | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| amt_sel_reg_i | input | 1 | 1: amount from rs_val_i[7:0]; 0: from amt_imm_i |
| amt_imm_i | input | 5 | Shift amount from the instruction |
| rs_val_i | input | 32 | Register that supplies the shift amount |
| carry_i | input | 1 | Incoming carry flag |
| operand_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The unit has no state, so the assertions are immediate checks made whenever the inputs settle. They assume every input holds a known 0/1 value, and that the amount byte and shift code are stable while the outputs are compared. The bench meets this by driving every input from one task at the falling clock edge and holding it until the next. It leaves no input undriven, even the ones that immediate mode ignores.

// File: rtl/op2_pkg.sv
package op2_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/op2_rotr.sv
// Log-depth right rotator: stage s rotates by 2**s when amt_i[s] is set.
module op2_rotr #(
  parameter int W = 32
) (
  input  logic [W-1:0]         data_i,
  input  logic [$clog2(W)-1:0] amt_i,
  output logic [W-1:0]         data_o
);
  localparam int SW = $clog2(W);

  logic [W-1:0] stg [SW+1];

  assign stg[0] = data_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt_i[s] ? {stg[s][D-1:0], stg[s][W-1:D]} : stg[s];
  end

  assign data_o = stg[SW];
endmodule

// File: rtl/op2_imm_expand.sv
module op2_imm_expand #(
  parameter int W     = 32,
  parameter int VAL_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [VAL_W+ROT_W-1:0] imm_i,
  input  logic                   carry_i,
  output logic [W-1:0]           val_o,
  output logic                   carry_o
);
  localparam int SW = $clog2(W);

  logic [ROT_W-1:0] rot_cnt;
  logic [SW-1:0]    rot_amt;
  logic [W-1:0]     base;

  assign rot_cnt = imm_i[VAL_W+ROT_W-1:VAL_W];
  // rotation is twice the count
  assign rot_amt = SW'({rot_cnt, 1'b0});
  assign base    = W'(imm_i[VAL_W-1:0]);

  op2_rotr #(.W(W)) u_rot (
    .data_i (base),
    .amt_i  (rot_amt),
    .data_o (val_o)
  );

  assign carry_o = (rot_cnt == '0) ? carry_i : val_o[W-1];
endmodule

// File: rtl/op2_shift_core.sv
module op2_shift_core
  import op2_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  shift_kind_e      kind_i,
  input  logic             carry_i,
  output logic [W-1:0]     data_o,
  output logic             carry_o
);
  localparam int SW = $clog2(W);
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(W);

  logic [SW-1:0] lo;
  logic [SW-1:0] rot_amt;
  logic [SW-1:0] lsl_idx;
  logic [SW-1:0] rsh_idx;
  logic [W-1:0]  rot_val;
  logic [W-1:0]  mask_r;
  logic [W-1:0]  mask_l;
  logic          amt_zero;
  logic          amt_full;
  logic          amt_over;
  logic          sign;

  assign lo       = amt_i[SW-1:0];
  assign amt_zero = (amt_i == '0);
  assign amt_full = (amt_i == AMT_FULL);
  assign amt_over = (amt_i > AMT_FULL);
  assign sign     = data_i[W-1];

  // left shift = right rotate by (W - n) then mask
  assign lsl_idx = ~lo + 1'b1;
  assign rsh_idx = lo - 1'b1;
  assign rot_amt = (kind_i == SH_LSL) ? lsl_idx : lo;
  assign mask_r  = {W{1'b1}} >> lo;
  assign mask_l  = {W{1'b1}} << lo;

  op2_rotr #(.W(W)) u_rot (
    .data_i (data_i),
    .amt_i  (rot_amt),
    .data_o (rot_val)
  );

  always_comb begin
    data_o  = data_i;
    carry_o = carry_i;
    if (!amt_zero) begin
      unique case (kind_i)
        SH_LSL: begin
          if (amt_full) begin
            data_o  = '0;
            carry_o = data_i[0];
          end else if (amt_over) begin
            data_o  = '0;
            carry_o = 1'b0;
          end else begin
            data_o  = rot_val & mask_l;
            carry_o = data_i[lsl_idx];
          end
        end
        SH_LSR: begin
          if (amt_full) begin
            data_o  = '0;
            carry_o = data_i[W-1];
          end else if (amt_over) begin
            data_o  = '0;
            carry_o = 1'b0;
          end else begin
            data_o  = rot_val & mask_r;
            carry_o = data_i[rsh_idx];
          end
        end
        SH_ASR: begin
          if (amt_full || amt_over) begin
            data_o  = {W{sign}};
            carry_o = sign;
          end else begin
            data_o  = (rot_val & mask_r) | ({W{sign}} & ~mask_r);
            carry_o = data_i[rsh_idx];
          end
        end
        SH_ROR: begin
          if (lo == '0) begin
            data_o  = data_i;
            carry_o = data_i[W-1];
          end else begin
            data_o  = rot_val;
            carry_o = rot_val[W-1];
          end
        end
        default: begin
          data_o  = data_i;
          carry_o = carry_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
  import op2_pkg::*;
#(
  parameter int W      = 32,
  parameter int VAL_W  = 8,
  parameter int ROT_W  = 4,
  parameter int SHIM_W = 5,
  parameter int AMT_W  = 8
) (
  input  logic                   imm_mode_i,
  input  logic [VAL_W+ROT_W-1:0] imm12_i,
  input  logic [W-1:0]           rm_val_i,
  input  logic [1:0]             shift_code_i,
  input  logic                   amt_sel_reg_i,
  input  logic [SHIM_W-1:0]      amt_imm_i,
  input  logic [W-1:0]           rs_val_i,
  input  logic                   carry_i,
  output logic [W-1:0]           operand_o,
  output logic                   carry_o
);
  logic [AMT_W-1:0] amt;
  logic [W-1:0]     imm_val;
  logic             imm_c;
  logic [W-1:0]     sh_val;
  logic             sh_c;
  logic             unused_rs_hi;

  assign unused_rs_hi = ^rs_val_i[W-1:AMT_W];
  assign amt = amt_sel_reg_i ? rs_val_i[AMT_W-1:0] : AMT_W'(amt_imm_i);

  op2_imm_expand #(.W(W), .VAL_W(VAL_W), .ROT_W(ROT_W)) u_imm (
    .imm_i   (imm12_i),
    .carry_i (carry_i),
    .val_o   (imm_val),
    .carry_o (imm_c)
  );

  op2_shift_core #(.W(W), .AMT_W(AMT_W)) u_sh (
    .data_i  (rm_val_i),
    .amt_i   (amt),
    .kind_i  (shift_kind_e'(shift_code_i)),
    .carry_i (carry_i),
    .data_o  (sh_val),
    .carry_o (sh_c)
  );

  assign operand_o = imm_mode_i ? imm_val : sh_val;
  assign carry_o   = imm_mode_i ? imm_c   : sh_c;
endmodule

// File: rtl/op2_shifter_chk.sv
module op2_shifter_chk #(
  parameter int W      = 32,
  parameter int VAL_W  = 8,
  parameter int ROT_W  = 4,
  parameter int SHIM_W = 5,
  parameter int AMT_W  = 8
) (
  input logic                   imm_mode_i,
  input logic [VAL_W+ROT_W-1:0] imm12_i,
  input logic [W-1:0]           rm_val_i,
  input logic [1:0]             shift_code_i,
  input logic                   amt_sel_reg_i,
  input logic [SHIM_W-1:0]      amt_imm_i,
  input logic [W-1:0]           rs_val_i,
  input logic                   carry_i,
  input logic [W-1:0]           operand_o,
  input logic                   carry_o
);
  logic [AMT_W-1:0] eff_amt;
  logic             unused_hi;

  assign unused_hi = ^rs_val_i[W-1:AMT_W];
  assign eff_amt = amt_sel_reg_i ? rs_val_i[AMT_W-1:0] : AMT_W'(amt_imm_i);

  always_comb begin
    if (imm_mode_i && imm12_i[VAL_W+ROT_W-1:VAL_W] == '0) begin
      a_r1_imm_no_rot: assert (operand_o == W'(imm12_i[VAL_W-1:0]) && carry_o == carry_i)
        else $error("R1 plain immediate mismatch");
    end
    if (imm_mode_i) begin
      a_r2_imm_bits_kept: assert ($countones(operand_o) == $countones(imm12_i[VAL_W-1:0]))
        else $error("R2 rotated immediate lost bits");
    end
    if (!imm_mode_i && eff_amt == '0) begin
      a_r4_zero_amt_pass: assert (operand_o == rm_val_i && carry_o == carry_i)
        else $error("R4 zero amount changed operand");
    end
    if (!imm_mode_i && shift_code_i != 2'b10 && shift_code_i != 2'b11 && eff_amt > AMT_W'(W)) begin
      a_r5_r6_over_zero: assert (operand_o == '0 && !carry_o)
        else $error("R5/R6 oversized shift not zero");
    end
    if (!imm_mode_i && shift_code_i == 2'b10 && eff_amt >= AMT_W'(W)) begin
      a_r7_asr_sign_fill: assert (operand_o == {W{rm_val_i[W-1]}} && carry_o == rm_val_i[W-1])
        else $error("R7 oversized ASR not sign fill");
    end
    if (!imm_mode_i && shift_code_i == 2'b11) begin
      a_r8_ror_bits_kept: assert ($countones(operand_o) == $countones(rm_val_i))
        else $error("R8 rotate lost bits");
    end
  end
endmodule

bind op2_shifter op2_shifter_chk #(
  .W(W), .VAL_W(VAL_W), .ROT_W(ROT_W), .SHIM_W(SHIM_W), .AMT_W(AMT_W)
) u_chk (.*);

// File: tb/sim_op2_shifter.sv
`timescale 1ns/1ps
module sim_op2_shifter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imm_mode;
  logic [11:0] imm12;
  logic [31:0] rm_val;
  logic [1:0]  code;
  logic        sel_reg;
  logic [4:0]  amt_imm;
  logic [31:0] rs_val;
  logic        cin;
  logic [31:0] op_o;
  logic        c_o;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  op2_shifter u0 (
    .imm_mode_i    (imm_mode),
    .imm12_i       (imm12),
    .rm_val_i      (rm_val),
    .shift_code_i  (code),
    .amt_sel_reg_i (sel_reg),
    .amt_imm_i     (amt_imm),
    .rs_val_i      (rs_val),
    .carry_i       (cin),
    .operand_o     (op_o),
    .carry_o       (c_o)
  );

  // bit-serial reference model
  task automatic ref_shift(input logic [31:0] x, input int n, input logic [1:0] k,
                           input logic ci, output logic [31:0] r, output logic c);
    r = x;
    c = ci;
    for (int i = 0; i < n; i++) begin
      case (k)
        2'b00: begin c = r[31]; r = r << 1; end
        2'b01: begin c = r[0];  r = r >> 1; end
        2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endtask

  task automatic ref_imm(input logic [11:0] f, input logic ci,
                         output logic [31:0] r, output logic c);
    r = {24'd0, f[7:0]};
    for (int i = 0; i < 2 * int'(f[11:8]); i++) r = {r[0], r[31:1]};
    c = (f[11:8] == 4'd0) ? ci : r[31];
  endtask

  task automatic drive(input logic im, input logic [11:0] f, input logic [31:0] x,
                       input logic [1:0] k, input logic sr, input logic [4:0] ai,
                       input logic [31:0] rs, input logic ci);
    @(negedge clk);
    imm_mode = im; imm12 = f; rm_val = x; code = k;
    sel_reg = sr; amt_imm = ai; rs_val = rs; cin = ci;
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] er, input logic ec);
    total++;
    if (op_o !== er || c_o !== ec) begin
      bad++;
      $display("FAIL %s: got op=%h c=%b expected op=%h c=%b", req, op_o, c_o, er, ec);
    end
  endtask

  task automatic run_reg(input string req, input logic [31:0] x, input int n,
                         input logic [1:0] k, input logic ci);
    logic [31:0] er;
    logic        ec;
    ref_shift(x, n, k, ci, er, ec);
    if (n < 32 && n[0]) drive(1'b0, 12'hFFF, x, k, 1'b0, 5'(n), 32'h0, ci);
    else                drive(1'b0, 12'hFFF, x, k, 1'b1, 5'h1F, {24'hA5C3E1, 8'(n)}, ci);
    check(req, er, ec);
  endtask

  task automatic t_reset_state;
    drive(1'b0, 12'h0, 32'h0, 2'b00, 1'b0, 5'd0, 32'h0, 1'b0);
    check("R4 reset-state zero inputs", 32'h0, 1'b0);
  endtask

  task automatic t_imm;
    logic [31:0] er;
    logic        ec;
    drive(1'b1, 12'h0FF, 32'hDEADBEEF, 2'b11, 1'b1, 5'd7, 32'h3, 1'b1);
    check("R1 rot 0 byte FF", 32'h0000_00FF, 1'b1);
    drive(1'b1, 12'h4AB, 32'h0, 2'b00, 1'b0, 5'd0, 32'h0, 1'b0);
    check("R2 rot 4 byte in top", 32'hAB00_0000, 1'b1);
    drive(1'b1, 12'hF81, 32'h0, 2'b00, 1'b0, 5'd0, 32'h0, 1'b1);
    check("R2 rot 15 wraps", 32'h0000_0204, 1'b0);
    for (int f = 0; f < 4096; f += 97) begin
      ref_imm(12'(f), f[2], er, ec);
      drive(1'b1, 12'(f), 32'h8000_0001 ^ 32'(f), 2'(f), f[0], 5'(f), 32'(f), f[2]);
      check("R2 immediate sweep", er, ec);
    end
  endtask

  task automatic t_imm_ignores;
    drive(1'b1, 12'h13C, 32'hFFFF_FFFF, 2'b10, 1'b1, 5'd31, 32'hFFFF_FFFF, 1'b0);
    check("R10 imm ignores reg inputs a", 32'h0000_000F, 1'b0);
    drive(1'b1, 12'h13C, 32'h0, 2'b00, 1'b0, 5'd0, 32'h0, 1'b0);
    check("R10 imm ignores reg inputs b", 32'h0000_000F, 1'b0);
  endtask

  task automatic t_zero_amt;
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 12'h0, 32'h9234_5678, 2'(k), 1'b0, 5'd0, 32'h0, 1'b1);
      check("R4 zero imm amount", 32'h9234_5678, 1'b1);
      drive(1'b0, 12'h0, 32'h9234_5678, 2'(k), 1'b1, 5'd9, 32'h1234_5600, 1'b0);
      check("R4 zero reg amount", 32'h9234_5678, 1'b0);
    end
  endtask

  task automatic t_amt_src;
    drive(1'b0, 12'h0, 32'h0000_00F0, 2'b01, 1'b1, 5'd1, 32'hFFFF_FF04, 1'b0);
    check("R3 reg amount low byte only", 32'h0000_000F, 1'b0);
    drive(1'b0, 12'h0, 32'h0000_00F0, 2'b01, 1'b0, 5'd4, 32'hFFFF_FF01, 1'b0);
    check("R3 imm amount used", 32'h0000_000F, 1'b0);
  endtask

  task automatic t_lsl;
    run_reg("R5 lsl 4", 32'h1234_5678, 4, 2'b00, 1'b0);
    run_reg("R5 lsl 31", 32'h0000_0003, 31, 2'b00, 1'b0);
    run_reg("R5 lsl 32", 32'h0000_0001, 32, 2'b00, 1'b0);
    run_reg("R5 lsl 33", 32'hFFFF_FFFF, 33, 2'b00, 1'b1);
  endtask

  task automatic t_lsr;
    run_reg("R6 lsr 8", 32'h8765_4321, 8, 2'b01, 1'b0);
    run_reg("R6 lsr 1", 32'h8000_0001, 1, 2'b01, 1'b0);
    run_reg("R6 lsr 32", 32'h8000_0000, 32, 2'b01, 1'b0);
    run_reg("R6 lsr 200", 32'hFFFF_FFFF, 200, 2'b01, 1'b1);
  endtask

  task automatic t_asr;
    run_reg("R7 asr 7 neg", 32'h8000_0080, 7, 2'b10, 1'b0);
    run_reg("R7 asr 7 pos", 32'h7000_0040, 7, 2'b10, 1'b1);
    run_reg("R7 asr 32 neg", 32'h8000_0000, 32, 2'b10, 1'b0);
    run_reg("R7 asr 255 pos", 32'h7FFF_FFFF, 255, 2'b10, 1'b1);
  endtask

  task automatic t_ror;
    run_reg("R8 ror 12", 32'h1234_5678, 12, 2'b11, 1'b0);
    run_reg("R8 ror 32", 32'h8000_0001, 32, 2'b11, 1'b0);
    run_reg("R8 ror 64", 32'h0000_0001, 64, 2'b11, 1'b1);
    run_reg("R8 ror 37", 32'h0000_0010, 37, 2'b11, 1'b0);
  endtask

  task automatic t_rotl;
    logic [31:0] x;
    x = 32'hC001_D00D;
    for (int n = 1; n < 32; n += 5) begin
      drive(1'b0, 12'h0, x, 2'b11, 1'b0, 5'(32 - n), 32'h0, 1'b0);
      check("R9 left rotate via ror", (x << n) | (x >> (32 - n)), ((x << n) >> 31) == 32'd1 ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_sweep;
    logic [31:0] pats [3];
    pats[0] = 32'hF0F0_1234;
    pats[1] = 32'h0F0F_EDCB;
    pats[2] = 32'h8000_0001;
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 70; n++)
          run_reg(k == 0 ? "R5 sweep" : k == 1 ? "R6 sweep" : k == 2 ? "R7 sweep" : "R8 sweep",
                  pats[p], n, 2'(k), n[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    imm_mode = 1'b0; imm12 = '0; rm_val = '0; code = '0;
    sel_reg = 1'b0; amt_imm = '0; rs_val = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_imm();
    t_imm_ignores();
    t_zero_amt();
    t_amt_src();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_rotl();
    t_sweep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule